// File: doc/BRIEF.md
# Circular-Buffer Data Address Generator

This block produces 24-bit data-memory addresses for indirect accesses. It holds four 16-bit index pointers. Each access request names one pointer and one of four signed modify registers. The block returns either the old pointer value (post-modify) or the stepped value (pre-modify). In both cases it writes the stepped value back into the pointer. Each pointer has a length register and a base register. When the length is non-zero, the stepped value is folded back into the window from base to base+length-1, so the pointer walks a circular buffer. An 8-bit page register supplies the upper address byte. The 16-bit offset arithmetic never carries into the page, so a buffer stays inside its 64K-word page.

Two complete register sets exist, a primary set and a secondary set. A set-select input picks which set serves accesses, register writes and register reads. Switching sets takes effect at once and copies nothing, which allows a context switch in a single cycle. Software-visible loads and reads of every register go through a simple write port and a combinational read port that both act on the active set.

Top module: `circ_agen`

## Requirements
- R1: After reset every index, modify, length, base and page register in both sets is zero, `addr_valid` is 0 and `addr_out` is 0.
- R2: With `wr_en` high, the register of the active set chosen by `wr_kind` (0 index, 1 modify, 2 length, 3 base, 4 page) and `wr_idx` takes `wr_data` at the clock edge. `rd_data` combinationally shows the active-set register chosen by `rd_kind`/`rd_idx`. A page read returns the page in bits 7:0 with zeros above.
- R3: Post-modify (`acc_pre`=0): one cycle after a request, `addr_out` = {page, old pointer}, and the pointer holds the stepped value.
- R4: Pre-modify (`acc_pre`=1): one cycle after a request, `addr_out` = {page, stepped value}, and the pointer holds that same value.
- R5: With length zero, the stepped value is pointer + modify modulo 2^16, where modify is read as a signed 16-bit number.
- R6: With a non-zero length, a sum of pointer and modify at or above base+length (computed without truncation) has length subtracted.
- R7: With a non-zero length, a sum below base has length added.
- R8: `addr_out[23:16]` equals the active set's page register at the time of the request. Neither wrap nor 16-bit carry ever changes it.
- R9: `bank_sel` (0 primary, 1 secondary) selects the active set. The inactive set's registers do not change, whatever accesses or writes occur.
- R10: When a write to an index register and an access to the same pointer happen in one cycle, the pointer takes the written value. The address output is still formed from the old contents.
- R11: `addr_valid` is high exactly in the cycle after a request. Without a request, `addr_out` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bank_sel | input | 1 | Active register set: 0 primary, 1 secondary |
| acc_valid | input | 1 | Access request |
| acc_ptr | input | 2 | Index pointer used by the access |
| acc_mod | input | 2 | Modify register used by the access |
| acc_pre | input | 1 | 1 pre-modify, 0 post-modify |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 3 | Register class to write |
| wr_idx | input | 2 | Register number within the class |
| wr_data | input | 16 | Write data |
| rd_kind | input | 3 | Register class to read |
| rd_idx | input | 2 | Register number to read |
| rd_data | output | 16 | Read data from the active set |
| addr_out | output | 24 | Generated address {page, offset} |
| addr_valid | output | 1 | Address valid, one cycle after a request |

## Verification
The address and its valid flag are registered: they appear one rising edge after the cycle that carries the request. Pointer write-back and register loads land on that same edge, so the new contents show on the combinational read port right after it. The bench drives every input on the falling edge and computes the expected address from its own model before the rising edge. It then compares at the next falling edge. Register reads are checked a short delay after the falling edge, with no clock edge in between, so the read port is judged on settled state only.

// File: rtl/circ_agen_pkg.sv
package circ_agen_pkg;

  typedef enum logic [2:0] {
    KIND_INDEX  = 3'd0,
    KIND_MODIFY = 3'd1,
    KIND_LENGTH = 3'd2,
    KIND_BASE   = 3'd3,
    KIND_PAGE   = 3'd4
  } reg_kind_e;

endpackage

// File: rtl/circ_agen_step.sv
module circ_agen_step #(
  parameter int OFS_W = 16
) (
  input  logic [OFS_W-1:0] cur_ptr,
  input  logic [OFS_W-1:0] mod_val,
  input  logic [OFS_W-1:0] len_val,
  input  logic [OFS_W-1:0] base_val,
  output logic [OFS_W-1:0] next_ptr,
  output logic             wrap_hi,
  output logic             wrap_lo
);
  localparam int SW = OFS_W + 2;

  // unsigned value widened to a non-negative signed number
  function automatic logic signed [SW-1:0] widen_u(input logic [OFS_W-1:0] v);
    return $signed({2'b00, v});
  endfunction

  // signed modify value widened with sign extension
  function automatic logic signed [SW-1:0] widen_s(input logic [OFS_W-1:0] v);
    return $signed({{2{v[OFS_W-1]}}, v});
  endfunction

  logic signed [SW-1:0] sum_w, lo_w, hi_w, res_w;
  logic                 circ_on;

  always_comb begin
    circ_on = (len_val != '0);
    sum_w   = widen_u(cur_ptr) + widen_s(mod_val);
    lo_w    = widen_u(base_val);
    hi_w    = lo_w + widen_u(len_val);
    wrap_hi = circ_on && (sum_w >= hi_w);
    wrap_lo = circ_on && !wrap_hi && (sum_w < lo_w);
    if (wrap_hi)      res_w = sum_w - widen_u(len_val);
    else if (wrap_lo) res_w = sum_w + widen_u(len_val);
    else              res_w = sum_w;
    next_ptr = res_w[OFS_W-1:0];
  end

endmodule

// File: rtl/circ_agen_regset.sv
module circ_agen_regset
  import circ_agen_pkg::*;
#(
  parameter int OFS_W  = 16,
  parameter int PAGE_W = 8,
  parameter int NPTR   = 4,
  parameter int IDX_W  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        active,
  input  logic                        wr_en,
  input  logic [2:0]                  wr_kind,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [OFS_W-1:0]            wr_data,
  input  logic                        upd_en,
  input  logic [IDX_W-1:0]            upd_idx,
  input  logic [OFS_W-1:0]            upd_val,
  output logic [NPTR-1:0][OFS_W-1:0]  ptr_q,
  output logic [NPTR-1:0][OFS_W-1:0]  mod_q,
  output logic [NPTR-1:0][OFS_W-1:0]  len_q,
  output logic [NPTR-1:0][OFS_W-1:0]  base_q,
  output logic [PAGE_W-1:0]           page_q
);

  logic wr_index, wr_modify, wr_length, wr_base, wr_page;

  always_comb begin
    wr_index  = active && wr_en && (wr_kind == KIND_INDEX);
    wr_modify = active && wr_en && (wr_kind == KIND_MODIFY);
    wr_length = active && wr_en && (wr_kind == KIND_LENGTH);
    wr_base   = active && wr_en && (wr_kind == KIND_BASE);
    wr_page   = active && wr_en && (wr_kind == KIND_PAGE);
  end

  for (genvar i = 0; i < NPTR; i++) begin : g_slot
    logic hit_wr;
    logic hit_upd;
    assign hit_wr  = (wr_idx == IDX_W'(i));
    assign hit_upd = active && upd_en && (upd_idx == IDX_W'(i));

    // explicit load wins over the access write-back
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  ptr_q[i] <= '0;
      else if (wr_index && hit_wr) ptr_q[i] <= wr_data;
      else if (hit_upd)            ptr_q[i] <= upd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mod_q[i]  <= '0;
        len_q[i]  <= '0;
        base_q[i] <= '0;
      end else begin
        if (wr_modify && hit_wr) mod_q[i]  <= wr_data;
        if (wr_length && hit_wr) len_q[i]  <= wr_data;
        if (wr_base   && hit_wr) base_q[i] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       page_q <= '0;
    else if (wr_page) page_q <= wr_data[PAGE_W-1:0];
  end

endmodule

// File: rtl/circ_agen.sv
module circ_agen
  import circ_agen_pkg::*;
#(
  parameter int  OFS_W  = 16,
  parameter int  PAGE_W = 8,
  parameter int  NPTR   = 4,
  localparam int IDX_W  = $clog2(NPTR),
  localparam int ADDR_W = OFS_W + PAGE_W,
  localparam int NSETS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_sel,
  input  logic              acc_valid,
  input  logic [IDX_W-1:0]  acc_ptr,
  input  logic [IDX_W-1:0]  acc_mod,
  input  logic              acc_pre,
  input  logic              wr_en,
  input  logic [2:0]        wr_kind,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [OFS_W-1:0]  wr_data,
  input  logic [2:0]        rd_kind,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [OFS_W-1:0]  rd_data,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_valid
);

  logic [NSETS-1:0][NPTR-1:0][OFS_W-1:0] ptr_all, mod_all, len_all, base_all;
  logic [NSETS-1:0][PAGE_W-1:0]          page_all;

  // named internal events, used by the bound checker
  logic [OFS_W-1:0]  sel_ptr;
  logic [OFS_W-1:0]  sel_mod;
  logic [OFS_W-1:0]  sel_len;
  logic [OFS_W-1:0]  sel_base;
  logic [PAGE_W-1:0] act_page;
  logic [OFS_W-1:0]  step_next;
  logic              step_wrap_hi;
  logic              step_wrap_lo;
  logic [OFS_W-1:0]  issue_ofs;

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    circ_agen_regset #(
      .OFS_W (OFS_W),
      .PAGE_W(PAGE_W),
      .NPTR  (NPTR),
      .IDX_W (IDX_W)
    ) u_set (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (bank_sel == 1'(s)),
      .wr_en  (wr_en),
      .wr_kind(wr_kind),
      .wr_idx (wr_idx),
      .wr_data(wr_data),
      .upd_en (acc_valid),
      .upd_idx(acc_ptr),
      .upd_val(step_next),
      .ptr_q  (ptr_all[s]),
      .mod_q  (mod_all[s]),
      .len_q  (len_all[s]),
      .base_q (base_all[s]),
      .page_q (page_all[s])
    );
  end

  always_comb begin
    sel_ptr  = ptr_all[bank_sel][acc_ptr];
    sel_mod  = mod_all[bank_sel][acc_mod];
    sel_len  = len_all[bank_sel][acc_ptr];
    sel_base = base_all[bank_sel][acc_ptr];
    act_page = page_all[bank_sel];
  end

  circ_agen_step #(.OFS_W(OFS_W)) u_step (
    .cur_ptr (sel_ptr),
    .mod_val (sel_mod),
    .len_val (sel_len),
    .base_val(sel_base),
    .next_ptr(step_next),
    .wrap_hi (step_wrap_hi),
    .wrap_lo (step_wrap_lo)
  );

  assign issue_ofs = acc_pre ? step_next : sel_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      addr_out   <= '0;
    end else begin
      addr_valid <= acc_valid;
      if (acc_valid) addr_out <= {act_page, issue_ofs};
    end
  end

  always_comb begin
    unique case (rd_kind)
      KIND_INDEX:  rd_data = ptr_all[bank_sel][rd_idx];
      KIND_MODIFY: rd_data = mod_all[bank_sel][rd_idx];
      KIND_LENGTH: rd_data = len_all[bank_sel][rd_idx];
      KIND_BASE:   rd_data = base_all[bank_sel][rd_idx];
      KIND_PAGE:   rd_data = OFS_W'(page_all[bank_sel]);
      default:     rd_data = '0;
    endcase
  end

endmodule

// File: rtl/circ_agen_chk.sv
module circ_agen_chk #(
  parameter int OFS_W  = 16,
  parameter int PAGE_W = 8,
  parameter int NPTR   = 4,
  parameter int IDX_W  = 2,
  parameter int ADDR_W = 24
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                bank_sel,
  input logic                                acc_valid,
  input logic                                acc_pre,
  input logic [IDX_W-1:0]                    acc_ptr,
  input logic                                wr_en,
  input logic [2:0]                          wr_kind,
  input logic [IDX_W-1:0]                    wr_idx,
  input logic [OFS_W-1:0]                    wr_data,
  input logic [OFS_W-1:0]                    sel_ptr,
  input logic [OFS_W-1:0]                    sel_mod,
  input logic [OFS_W-1:0]                    sel_len,
  input logic [OFS_W-1:0]                    sel_base,
  input logic [PAGE_W-1:0]                   act_page,
  input logic [OFS_W-1:0]                    step_next,
  input logic [1:0][NPTR-1:0][OFS_W-1:0]     ptr_all,
  input logic [ADDR_W-1:0]                   addr_out,
  input logic                                addr_valid
);
  localparam int SW = OFS_W + 2;

  logic [SW-1:0] lo_w, hi_w, cur_w, nxt_w, mag_w;
  logic          in_window, small_step;
  always_comb begin
    lo_w       = SW'(sel_base);
    hi_w       = SW'(sel_base) + SW'(sel_len);
    cur_w      = SW'(sel_ptr);
    nxt_w      = SW'(step_next);
    mag_w      = sel_mod[OFS_W-1] ? SW'(-sel_mod) : SW'(sel_mod);
    in_window  = (cur_w >= lo_w) && (cur_w < hi_w);
    small_step = (mag_w <= SW'(sel_len));
  end

  // R11
  addr_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> addr_valid);

  // R11
  addr_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !addr_valid && $stable(addr_out));

  // R3
  post_mod_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_pre |=> addr_out[OFS_W-1:0] == $past(sel_ptr));

  // R4
  pre_mod_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_pre |=> addr_out[OFS_W-1:0] == $past(step_next));

  // R8
  page_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> addr_out[ADDR_W-1:OFS_W] == $past(act_page));

  // R6 R7
  stay_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && (sel_len != '0) && in_window && small_step
      |-> (nxt_w >= lo_w) && (nxt_w < hi_w));

  // R9
  idle_set1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_sel |=> ptr_all[1] == $past(ptr_all[1]));

  // R9
  idle_set0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_sel |=> ptr_all[0] == $past(ptr_all[0]));

  // R10
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && wr_en && (wr_kind == 3'd0) && (wr_idx == acc_ptr)
      |=> ptr_all[$past(bank_sel)][$past(wr_idx)] == $past(wr_data));

endmodule

bind circ_agen circ_agen_chk #(
  .OFS_W (OFS_W),
  .PAGE_W(PAGE_W),
  .NPTR  (NPTR),
  .IDX_W (IDX_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bank_sel  (bank_sel),
  .acc_valid (acc_valid),
  .acc_pre   (acc_pre),
  .acc_ptr   (acc_ptr),
  .wr_en     (wr_en),
  .wr_kind   (wr_kind),
  .wr_idx    (wr_idx),
  .wr_data   (wr_data),
  .sel_ptr   (sel_ptr),
  .sel_mod   (sel_mod),
  .sel_len   (sel_len),
  .sel_base  (sel_base),
  .act_page  (act_page),
  .step_next (step_next),
  .ptr_all   (ptr_all),
  .addr_out  (addr_out),
  .addr_valid(addr_valid)
);

// File: tb/test_circ_agen.sv
module test_circ_agen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bank_sel = 1'b0;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_ptr = '0;
  logic [1:0]  acc_mod = '0;
  logic        acc_pre = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_kind = '0;
  logic [1:0]  wr_idx = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_kind = '0;
  logic [1:0]  rd_idx = '0;
  logic [15:0] rd_data;
  logic [23:0] addr_out;
  logic        addr_valid;

  circ_agen i_circ_agen (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
    .acc_valid(acc_valid), .acc_ptr(acc_ptr), .acc_mod(acc_mod), .acc_pre(acc_pre),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_kind(rd_kind), .rd_idx(rd_idx), .rd_data(rd_data),
    .addr_out(addr_out), .addr_valid(addr_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // bench model: [set][slot]
  logic [15:0] m_ptr [2][4];
  logic [15:0] m_mod [2][4];
  logic [15:0] m_len [2][4];
  logic [15:0] m_base[2][4];
  logic [7:0]  m_page[2];
  logic [23:0] last_addr = '0;

  // circular step restated with plain integers
  function automatic logic [15:0] model_step(logic [15:0] p, logic [15:0] m,
                                            logic [15:0] l, logic [15:0] b);
    int s;
    s = int'(p) + int'($signed(m));
    if (l != 0) begin
      if (s >= int'(b) + int'(l)) s = s - int'(l);
      else if (s < int'(b))       s = s + int'(l);
    end
    return 16'(s);
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp, string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  // one clock: drive at falling edge, compare at the next falling edge
  task automatic cycle(string tag, logic sel, logic av, logic [1:0] ap, logic [1:0] am,
                       logic pre, logic we, logic [2:0] wk, logic [1:0] wi, logic [15:0] wd);
    logic [15:0] cur, nxt;
    logic [23:0] exp_addr;
    bank_sel = sel; acc_valid = av; acc_ptr = ap; acc_mod = am; acc_pre = pre;
    wr_en = we; wr_kind = wk; wr_idx = wi; wr_data = wd;
    exp_addr = last_addr;
    if (av) begin
      cur = m_ptr[sel][ap];
      nxt = model_step(cur, m_mod[sel][am], m_len[sel][ap], m_base[sel][ap]);
      exp_addr = {m_page[sel], pre ? nxt : cur};
      m_ptr[sel][ap] = nxt;
    end
    if (we) begin
      case (wk)
        3'd0: m_ptr[sel][wi]  = wd;
        3'd1: m_mod[sel][wi]  = wd;
        3'd2: m_len[sel][wi]  = wd;
        3'd3: m_base[sel][wi] = wd;
        3'd4: m_page[sel]     = wd[7:0];
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0; wr_en = 1'b0;
    check(tag, 32'(addr_valid), 32'(av), "addr_valid");
    check(tag, 32'(addr_out), 32'(exp_addr), "addr_out");
    last_addr = exp_addr;
  endtask

  task automatic wr(string tag, logic sel, logic [2:0] k, logic [1:0] i, logic [15:0] d);
    cycle(tag, sel, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, k, i, d);
  endtask

  task automatic acc(string tag, logic sel, logic [1:0] p, logic [1:0] m, logic pre);
    cycle(tag, sel, 1'b1, p, m, pre, 1'b0, 3'd0, 2'd0, 16'h0);
  endtask

  task automatic rd(string tag, logic sel, logic [2:0] k, logic [1:0] i);
    logic [15:0] exp;
    bank_sel = sel; rd_kind = k; rd_idx = i;
    #1;
    case (k)
      3'd0: exp = m_ptr[sel][i];
      3'd1: exp = m_mod[sel][i];
      3'd2: exp = m_len[sel][i];
      3'd3: exp = m_base[sel][i];
      3'd4: exp = {8'h00, m_page[sel]};
      default: exp = 16'h0;
    endcase
    check(tag, 32'(rd_data), 32'(exp), "rd_data");
  endtask

  task automatic rd_all(string tag);
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 5; k++)
        for (int i = 0; i < 4; i++)
          rd(tag, s[0], k[2:0], i[1:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    for (int s = 0; s < 2; s++) begin
      m_page[s] = '0;
      for (int i = 0; i < 4; i++) begin
        m_ptr[s][i] = '0; m_mod[s][i] = '0; m_len[s][i] = '0; m_base[s][i] = '0;
      end
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", 32'(addr_valid), 32'd0, "addr_valid in reset");
    check("R1", 32'(addr_out), 32'd0, "addr_out in reset");
    rst_n = 1'b1;
    @(negedge clk);
    rd_all("R1");

    // R2: loads into the primary set
    wr("R2", 1'b0, 3'd0, 2'd0, 16'h0100);
    wr("R2", 1'b0, 3'd3, 2'd0, 16'h0100);
    wr("R2", 1'b0, 3'd2, 2'd0, 16'd8);
    wr("R2", 1'b0, 3'd1, 2'd0, 16'd3);
    wr("R2", 1'b0, 3'd1, 2'd1, 16'hFFFD);
    wr("R2", 1'b0, 3'd4, 2'd0, 16'hAB12);
    rd("R2", 1'b0, 3'd0, 2'd0);
    rd("R2", 1'b0, 3'd1, 2'd1);
    rd("R2", 1'b0, 3'd4, 2'd0);

    // R3 post-modify stepping up, R6 wrap at the top end: 100,103,106 -> 101
    acc("R3", 1'b0, 2'd0, 2'd0, 1'b0);
    acc("R3", 1'b0, 2'd0, 2'd0, 1'b0);
    acc("R6", 1'b0, 2'd0, 2'd0, 1'b0);
    check("R6", 32'(addr_out), 32'h120106, "post addr before top wrap");
    rd("R6", 1'b0, 3'd0, 2'd0);
    check("R6", 32'(rd_data), 32'h0101, "pointer after top wrap");

    // R4 pre-modify stepping down, R7 wrap at the bottom end: 101 - 3 -> 106
    acc("R7", 1'b0, 2'd0, 2'd1, 1'b1);
    check("R4", 32'(addr_out), 32'h120106, "pre addr after bottom wrap");
    acc("R4", 1'b0, 2'd0, 2'd1, 1'b1);
    check("R4", 32'(addr_out), 32'h120103, "pre addr step down");

    // R5 linear mode and R8 page unaffected by 16-bit carry
    wr("R5", 1'b0, 3'd0, 2'd1, 16'hFFFE);
    acc("R5", 1'b0, 2'd1, 2'd0, 1'b1);
    check("R8", 32'(addr_out), 32'h120001, "carry kept out of page");
    rd("R5", 1'b0, 3'd0, 2'd1);

    // R9 secondary set contents independent of primary
    wr("R9", 1'b1, 3'd0, 2'd0, 16'h0500);
    wr("R9", 1'b1, 3'd4, 2'd0, 16'h0034);
    wr("R9", 1'b1, 3'd1, 2'd2, 16'd16);
    acc("R9", 1'b1, 2'd0, 2'd2, 1'b0);
    check("R9", 32'(addr_out), 32'h340500, "secondary set address");
    rd_all("R9");

    // R10 simultaneous load and access to the same pointer
    cycle("R10", 1'b1, 1'b1, 2'd0, 2'd2, 1'b1, 1'b1, 3'd0, 2'd0, 16'h0777);
    rd("R10", 1'b1, 3'd0, 2'd0);
    check("R10", 32'(rd_data), 32'h0777, "load beats write-back");

    // R11 idle cycles hold the last address
    cycle("R11", 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 2'd0, 16'h0);
    cycle("R11", 1'b0, 1'b0, 2'd3, 2'd3, 1'b1, 1'b0, 3'd0, 2'd0, 16'h0);

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      logic sel, av, we, pre;
      logic [1:0] ap, am, wi;
      logic [2:0] wk;
      logic [15:0] wd;
      sel = 1'($urandom_range(0, 1));
      av  = ($urandom_range(0, 3) != 0);
      we  = ($urandom_range(0, 3) == 0);
      pre = 1'($urandom_range(0, 1));
      ap  = 2'($urandom_range(0, 3));
      am  = 2'($urandom_range(0, 3));
      wi  = 2'($urandom_range(0, 3));
      wk  = 3'($urandom_range(0, 4));
      case (wk)
        3'd1: wd = 16'($signed($urandom_range(0, 24)) - 12);
        3'd2: wd = ($urandom_range(0, 4) == 0) ? 16'd0 : 16'($urandom_range(12, 40));
        default: wd = 16'($urandom);
      endcase
      cycle(pre ? "R4" : "R3", sel, av, ap, am, pre, we, wk, wi, wd);
    end
    rd_all("R9");

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule